// File: doc/BRIEF.md
# Clock Reference Qualifier and Selector

This block sits in the system-clock domain in front of one timing loop. It watches up to four clock references. Each reference arrives as a one-cycle edge pulse that has already been synchronised. For every reference the block checks two things: that edges keep arriving, and that the spacing between consecutive edges stays inside a tolerance window around a programmed nominal period. When a reference has been fault-free for a programmable number of milliseconds, it is declared usable.

From the usable references a small state machine picks the one that drives the loop. In automatic mode it takes the best programmed priority, with optional revertive switching. In manual mode it follows a software choice. When no suitable reference remains, it falls into holdover so that the loop keeps its last frequency. A one-cycle strobe marks every change of the chosen reference and every entry into or exit from holdover. The selector has two states:

- `ST_HOLD`: no reference is driving the loop.
- `ST_TRACK`: a reference is driving the loop.

Its transitions in automatic mode:

- **acquire**: HOLD to TRACK when any reference is usable.
- **fallback**: TRACK to TRACK with a new index when the current reference is lost.
- **revert**: TRACK to TRACK when a strictly better reference is usable and reverting is enabled.
- **starve**: TRACK to HOLD when no reference is usable.

In manual mode the selector is in TRACK when the chosen reference is usable and in HOLD when it is not.

Top module: `ref_arbiter`

## Requirements
- R1: A reference is flagged faulty when, after its previous edge, more than L = N + floor(N/8) + floor(N/32) system cycles pass without a new edge, where N is its programmed nominal period in cycles.
- R2: At each edge the cycle count P since the previous edge is compared with N. The fault flag is set when |P - N| > floor(N * T / 2^PPM_SHIFT), where T is the tolerance setting, and cleared otherwise. The first edge after reset only arms the measurement, so the flag stays set until a second edge arrives.
- R3: The valid flag rises only after the fault flag has stayed low for M milliseconds (TICKS_PER_MS cycles each; an M of 0 counts as 1). Any fault during that wait restarts it from zero.
- R4: A valid reference whose fault flag is set is reported not valid on the next cycle, unless it is forced.
- R5: In automatic mode, entering TRACK or falling back picks the valid reference with the smallest priority value (0 is best). On a tie the lowest index wins.
- R6: With revert_en = 1, a valid reference with a strictly smaller priority value than the current one takes over. With revert_en = 0 the current reference is kept while it stays valid.
- R7: In automatic mode, holdover is 1 on the cycle after no reference is valid, and 0 on the cycle after any reference is valid.
- R8: In manual mode (auto_mode = 0), the active index becomes manual_sel when that reference is valid. Otherwise the block goes to holdover, with no fallback to another reference.
- R9: A set force_valid bit makes that reference report valid and be selectable, whatever its fault flag shows.
- R10: switch_stb is high for exactly those cycles in which active_idx or holdover differs from its value in the previous cycle.
- R11: After reset, every fault flag is 1, every valid flag is 0, holdover = 1, active_idx = 0 and switch_stb = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_edge | input | NREF | Synchronised one-cycle edge pulse per reference |
| nom_period | input | NREF x PER_W | Nominal period per reference, in system cycles |
| tol_ppm | input | NREF x TOL_W | Frequency tolerance per reference, in units of 2^-PPM_SHIFT |
| val_ms | input | NREF x MS_W | Validation time per reference, in milliseconds |
| ref_prio | input | NREF x PRIO_W | Priority per reference, 0 is best |
| force_valid | input | NREF | Override that treats a reference as valid |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| manual_sel | input | log2(NREF) | Reference chosen in manual mode |
| revert_en | input | 1 | Allows a switch to a strictly better reference |
| ref_fault | output | NREF | Fault flag per reference |
| ref_valid | output | NREF | Valid flag per reference |
| active_idx | output | log2(NREF) | Index of the reference driving the loop |
| holdover | output | 1 | No reference is driving the loop |
| switch_stb | output | 1 | One-cycle change marker |

## Verification
The selector's state shows up directly at the ports. If the state register and the holdover flag disagree, or the index is stale, active_idx or holdover is wrong one cycle after ref_valid changes, and switch_stb appears or goes missing on that same cycle. A wrong gap counter or window calculation in a monitor shows up as a fault flag that is wrong within one reference period. A validation counter that fails to restart shows up as a valid flag that rises too early, within the validation time. The bench drives periods just inside and just outside the window, stops and restarts references, and randomises priorities and outages, so that each of these errors is seen well inside those limits.

// File: rtl/ref_arbiter_pkg.sv
package ref_arbiter_pkg;
    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } sel_state_t;
endpackage

// File: rtl/ref_monitor.sv
// Per-reference qualifier: loss-of-edge check, period window check, validation timer.
module ref_monitor #(
    parameter int PER_W        = 20,
    parameter int TOL_W        = 7,
    parameter int MS_W         = 16,
    parameter int TICKS_PER_MS = 125000,
    parameter int PPM_SHIFT    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [PER_W-1:0] nom_i,
    input  logic [TOL_W-1:0] tol_i,
    input  logic [MS_W-1:0]  vms_i,
    input  logic             force_i,
    output logic             fault_o,
    output logic             valid_o
);
    localparam int CW   = PER_W + 1;
    localparam int PW   = PER_W + TOL_W;
    localparam int TK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

    logic [CW-1:0]   gap_q, nom_x, loss_lim, dev;
    logic [PW-1:0]   prod, allow;
    logic            in_win, seen_q, flt_q, valid_q;
    logic [TK_W-1:0] tick_q;
    logic [MS_W-1:0] ms_q, ms_goal;

    assign nom_x    = {1'b0, nom_i};
    assign loss_lim = nom_x + (nom_x >> 3) + (nom_x >> 5);
    assign prod     = PW'(nom_i) * PW'(tol_i);
    assign allow    = prod >> PPM_SHIFT;
    assign dev      = (gap_q >= nom_x) ? (gap_q - nom_x) : (nom_x - gap_q);
    assign in_win   = (PW'(dev) <= allow);
    assign ms_goal  = (vms_i == '0) ? MS_W'(1) : vms_i;

    // Edge spacing and fault flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            flt_q  <= 1'b1;
        end else if (edge_i) begin
            flt_q  <= !(seen_q && in_win);
            seen_q <= 1'b1;
            gap_q  <= CW'(1);
        end else begin
            if (gap_q != '1)
                gap_q <= gap_q + CW'(1);
            if (seen_q && (gap_q > loss_lim))
                flt_q <= 1'b1;
        end
    end

    // Validation timer in millisecond steps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            ms_q    <= '0;
            valid_q <= 1'b0;
        end else if (flt_q) begin
            tick_q  <= '0;
            ms_q    <= '0;
            valid_q <= 1'b0;
        end else if (!valid_q) begin
            if (tick_q == TK_W'(TICKS_PER_MS - 1)) begin
                tick_q <= '0;
                if (({1'b0, ms_q} + (MS_W+1)'(1)) == {1'b0, ms_goal})
                    valid_q <= 1'b1;
                else
                    ms_q <= ms_q + MS_W'(1);
            end else begin
                tick_q <= tick_q + TK_W'(1);
            end
        end
    end

    assign fault_o = flt_q;
    assign valid_o = valid_q | force_i;
endmodule

// File: rtl/ref_picker.sv
// Selection state machine: priority choice, revertive switching, manual mode, holdover.
module ref_picker
    import ref_arbiter_pkg::*;
#(
    parameter int NREF   = 4,
    parameter int PRIO_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NREF-1:0]                 valid_i,
    input  logic [NREF-1:0][PRIO_W-1:0]     prio_i,
    input  logic                            auto_i,
    input  logic [$clog2(NREF)-1:0]         man_sel_i,
    input  logic                            revert_i,
    output logic [$clog2(NREF)-1:0]         idx_o,
    output logic                            hold_o,
    output logic                            strobe_o
);
    localparam int IDX_W = $clog2(NREF);

    sel_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d, best_idx;
    logic [PRIO_W-1:0] best_prio;
    logic              best_ok;

    // Best valid reference: smallest priority value, lowest index on a tie
    always_comb begin
        best_ok   = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NREF; i++) begin
            if (valid_i[i] && (!best_ok || (prio_i[i] < best_prio))) begin
                best_ok   = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_i[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (auto_i) begin
            unique case (state_q)
                ST_HOLD: begin
                    if (best_ok) begin
                        state_d = ST_TRACK;
                        idx_d   = best_idx;
                    end
                end
                ST_TRACK: begin
                    if (!valid_i[idx_q]) begin
                        if (best_ok) idx_d   = best_idx;
                        else         state_d = ST_HOLD;
                    end else if (revert_i && best_ok && (best_prio < prio_i[idx_q])) begin
                        idx_d = best_idx;
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end else if (valid_i[man_sel_i]) begin
            state_d = ST_TRACK;
            idx_d   = man_sel_i;
        end else begin
            state_d = ST_HOLD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            hold_o   <= 1'b1;
            strobe_o <= 1'b0;
        end else begin
            idx_q    <= idx_d;
            hold_o   <= (state_d == ST_HOLD);
            strobe_o <= (state_d != state_q) || (idx_d != idx_q);
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter #(
    parameter int NREF         = 4,
    parameter int PER_W        = 20,
    parameter int TOL_W        = 7,
    parameter int MS_W         = 16,
    parameter int PRIO_W       = 3,
    parameter int TICKS_PER_MS = 125000,
    parameter int PPM_SHIFT    = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREF-1:0]               ref_edge,
    input  logic [NREF-1:0][PER_W-1:0]    nom_period,
    input  logic [NREF-1:0][TOL_W-1:0]    tol_ppm,
    input  logic [NREF-1:0][MS_W-1:0]     val_ms,
    input  logic [NREF-1:0][PRIO_W-1:0]   ref_prio,
    input  logic [NREF-1:0]               force_valid,
    input  logic                          auto_mode,
    input  logic [$clog2(NREF)-1:0]       manual_sel,
    input  logic                          revert_en,
    output logic [NREF-1:0]               ref_fault,
    output logic [NREF-1:0]               ref_valid,
    output logic [$clog2(NREF)-1:0]       active_idx,
    output logic                          holdover,
    output logic                          switch_stb
);
    for (genvar i = 0; i < NREF; i++) begin : g_mon
        ref_monitor #(
            .PER_W(PER_W), .TOL_W(TOL_W), .MS_W(MS_W),
            .TICKS_PER_MS(TICKS_PER_MS), .PPM_SHIFT(PPM_SHIFT)
        ) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (ref_edge[i]),
            .nom_i   (nom_period[i]),
            .tol_i   (tol_ppm[i]),
            .vms_i   (val_ms[i]),
            .force_i (force_valid[i]),
            .fault_o (ref_fault[i]),
            .valid_o (ref_valid[i])
        );
    end

    ref_picker #(.NREF(NREF), .PRIO_W(PRIO_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (ref_valid),
        .prio_i    (ref_prio),
        .auto_i    (auto_mode),
        .man_sel_i (manual_sel),
        .revert_i  (revert_en),
        .idx_o     (active_idx),
        .hold_o    (holdover),
        .strobe_o  (switch_stb)
    );
endmodule

// File: rtl/ref_arbiter_chk.sv
module ref_arbiter_chk #(
    parameter int NREF = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NREF-1:0]         force_valid,
    input logic                    auto_mode,
    input logic [$clog2(NREF)-1:0] manual_sel,
    input logic [NREF-1:0]         ref_fault,
    input logic [NREF-1:0]         ref_valid,
    input logic [$clog2(NREF)-1:0] active_idx,
    input logic                    holdover,
    input logic                    switch_stb
);
    for (genvar i = 0; i < NREF; i++) begin : g_chk
        AST_FAULT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_fault[i] && !force_valid[i]) |=> (!ref_valid[i] || force_valid[i])); // R4
    end

    AST_HOLD_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && (ref_valid == '0)) |=> holdover); // R7

    AST_TRACK_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && (ref_valid != '0)) |=> !holdover); // R7

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && ref_valid[manual_sel]) |=> (!holdover && (active_idx == $past(manual_sel)))); // R8

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !ref_valid[manual_sel]) |=> holdover); // R8

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_idx != $past(active_idx)) || (holdover != $past(holdover))) |-> switch_stb); // R10

    AST_STROBE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        switch_stb |-> ((active_idx != $past(active_idx)) || (holdover != $past(holdover)))); // R10
endmodule

bind ref_arbiter ref_arbiter_chk #(.NREF(NREF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_valid (force_valid),
    .auto_mode   (auto_mode),
    .manual_sel  (manual_sel),
    .ref_fault   (ref_fault),
    .ref_valid   (ref_valid),
    .active_idx  (active_idx),
    .holdover    (holdover),
    .switch_stb  (switch_stb)
);

// File: tb/ref_arbiter_tb.sv
module ref_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREF  = 4;
    localparam int PER_W = 12;
    localparam int TOL_W = 7;
    localparam int MS_W  = 16;
    localparam int PRIO_W = 3;
    localparam int TICKS = 4;
    localparam int SHIFT = 10;
    localparam int NOM   = 64;
    localparam int TOL   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    wire  [NREF-1:0] ref_edge;
    logic [NREF-1:0][PER_W-1:0]  nom_period;
    logic [NREF-1:0][TOL_W-1:0]  tol_ppm;
    logic [NREF-1:0][MS_W-1:0]   val_ms;
    logic [NREF-1:0][PRIO_W-1:0] ref_prio;
    logic [NREF-1:0] force_valid = '0;
    logic auto_mode = 1'b1;
    logic [1:0] manual_sel = 2'd0;
    logic revert_en = 1'b0;
    logic [NREF-1:0] ref_fault, ref_valid;
    logic [1:0] active_idx;
    logic holdover, switch_stb;

    int per [NREF];
    int checks = 0;
    int errors = 0;
    int stb_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_arbiter #(
        .NREF(NREF), .PER_W(PER_W), .TOL_W(TOL_W), .MS_W(MS_W), .PRIO_W(PRIO_W),
        .TICKS_PER_MS(TICKS), .PPM_SHIFT(SHIFT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .nom_period(nom_period),
        .tol_ppm(tol_ppm), .val_ms(val_ms), .ref_prio(ref_prio), .force_valid(force_valid),
        .auto_mode(auto_mode), .manual_sel(manual_sel), .revert_en(revert_en),
        .ref_fault(ref_fault), .ref_valid(ref_valid), .active_idx(active_idx),
        .holdover(holdover), .switch_stb(switch_stb)
    );

    // Reference generators: one edge pulse every per[g] cycles, idle when per[g] < 2
    for (genvar g = 0; g < NREF; g++) begin : g_src
        logic e = 1'b0;
        assign ref_edge[g] = e;
        initial begin
            forever begin
                if (per[g] < 2) begin
                    @(negedge clk);
                end else begin
                    @(negedge clk); e = 1'b1;
                    @(negedge clk); e = 1'b0;
                    repeat (per[g] - 2) @(negedge clk);
                end
            end
        end
    end

    // R10 monitor: strobe must mark exactly the cycles where index or holdover moved
    logic [1:0] prev_idx = 2'd0;
    logic       prev_hold = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (switch_stb !== ((active_idx != prev_idx) || (holdover != prev_hold)))
                stb_err++;
            prev_idx  <= active_idx;
            prev_hold <= holdover;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit period_bad(input int p, input int n, input int t);
        int allow = (n * t) >> SHIFT;
        int d = (p > n) ? p - n : n - p;
        return d > allow;
    endfunction

    function automatic int min_prio(input logic [NREF-1:0] mask);
        int m = 99;
        for (int i = 0; i < NREF; i++)
            if (mask[i] && int'(ref_prio[i]) < m) m = int'(ref_prio[i]);
        return m;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NREF; i++) begin
            per[i] = 0;
            nom_period[i] = PER_W'(NOM);
            tol_ppm[i] = TOL_W'(TOL);
            val_ms[i] = MS_W'(3);
        end
        ref_prio = {3'd1, 3'd3, 3'd1, 3'd2};   // ref3..ref0
        void'($urandom(32'h5EED_0042));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R11 reset state
        chk("R11 fault", ref_fault, 4'hF);
        chk("R11 valid", ref_valid, 4'h0);
        chk("R11 holdover", holdover, 1);
        chk("R11 idx", active_idx, 0);
        chk("R11 strobe", switch_stb, 0);

        for (int i = 0; i < NREF; i++) per[i] = NOM;
        wait_cyc(400);
        chk("R3 all valid", ref_valid, 4'hF);
        chk("R2 in-window no fault", ref_fault, 4'h0);
        chk("R5 tie lowest index", active_idx, 1);
        chk("R7 leave holdover", holdover, 0);

        // R1 loss of edges on the active reference
        per[1] = 0;
        wait_cyc(90);
        chk("R1 loss fault", ref_fault[1], 1);
        chk("R4 valid dropped", ref_valid[1], 0);
        chk("R5 fallback", active_idx, 3);

        // R6 non-revertive, then revertive
        ref_prio[1] = 3'd0;
        per[1] = NOM;
        wait_cyc(400);
        chk("R3 revalidated", ref_valid[1], 1);
        chk("R6 no revert", active_idx, 3);
        revert_en = 1'b1;
        wait_cyc(5);
        chk("R6 revert", active_idx, 1);

        // R2 window edges on reference 2
        foreach (per[k]) if (k == 2) begin
            int pl [4] = '{67, 66, 61, 62};
            for (int j = 0; j < 4; j++) begin
                per[2] = pl[j];
                wait_cyc(300);
                chk($sformatf("R2 period %0d", pl[j]), ref_fault[2], period_bad(pl[j], NOM, TOL));
            end
        end
        per[2] = NOM;

        // R3 validation restart on a fault inside the wait
        per[0] = 0;
        wait_cyc(100);
        chk("R1 ref0 lost", ref_fault[0], 1);
        val_ms[0] = MS_W'(40);
        per[0] = NOM;
        wait_cyc(100);
        per[0] = 70;
        wait_cyc(50);
        per[0] = NOM;
        wait_cyc(150);
        chk("R3 cleared fault", ref_fault[0], 0);
        chk("R3 timer restarted", ref_valid[0], 0);
        wait_cyc(160);
        chk("R3 valid after restart", ref_valid[0], 1);
        val_ms[0] = MS_W'(3);

        // R7 holdover with every reference gone
        for (int i = 0; i < NREF; i++) per[i] = 0;
        wait_cyc(100);
        chk("R7 none valid", ref_valid, 4'h0);
        chk("R7 holdover", holdover, 1);
        for (int i = 0; i < NREF; i++) per[i] = NOM;
        wait_cyc(300);
        chk("R7 leave holdover", holdover, 0);

        // R8 manual
        auto_mode = 1'b0;
        manual_sel = 2'd2;
        wait_cyc(5);
        chk("R8 manual idx", active_idx, 2);
        chk("R8 manual track", holdover, 0);
        per[2] = 0;
        wait_cyc(100);
        chk("R8 manual no fallback", holdover, 1);

        // R9 override
        force_valid = 4'b0100;
        wait_cyc(5);
        chk("R9 forced valid", ref_valid[2], 1);
        chk("R9 fault still seen", ref_fault[2], 1);
        chk("R9 forced selectable", {holdover, active_idx}, {1'b0, 2'd2});
        force_valid = 4'b0000;
        per[2] = NOM;
        auto_mode = 1'b1;
        wait_cyc(300);

        // Random priorities and outages (R5, R7, R1)
        for (int it = 0; it < 8; it++) begin
            logic [NREF-1:0] run = NREF'($urandom_range(0, 15));
            for (int i = 0; i < NREF; i++) begin
                ref_prio[i] = PRIO_W'($urandom_range(0, 3));
                per[i] = run[i] ? NOM : 0;
            end
            wait_cyc(300);
            chk($sformatf("R1 random valid it%0d", it), ref_valid, run);
            if (run == '0) begin
                chk($sformatf("R7 random hold it%0d", it), holdover, 1);
            end else begin
                chk($sformatf("R5 random active valid it%0d", it), run[active_idx], 1);
                chk($sformatf("R5 random best prio it%0d", it), ref_prio[active_idx], min_prio(run));
                chk($sformatf("R7 random track it%0d", it), holdover, 0);
            end
        end

        chk("R10 strobe mismatches", stb_err, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule